// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor DMA Engine

This block is a small memory-to-memory copy engine that an interrupt controller starts. A trigger is accepted only when it comes with the highest priority level. It carries the address of a descriptor held in RAM. The engine reads four 16-bit descriptor words: a mode word, a unit count, a source pointer and a destination pointer. It then moves units of 8 or 16 bits through one 16-bit synchronous memory port that uses a request/ready handshake.

In burst mode one trigger runs the whole count back to back. The `hold` output stays high from the first descriptor read to the completion pulse, so the processor and all other interrupts stall for that time. In single mode each trigger moves one unit. The engine then writes the remaining count and the advanced pointers back into the descriptor, so the next trigger continues where this one stopped. Mode words that ask for features the engine lacks cause an error pulse, and no data moves.

Top module: `dmaeng_top`

## Requirements
- R1: A trigger is taken only when `trigLevel` equals 3'b111. A trigger at any other level leaves `hold` low, issues no memory access and changes no memory.
- R2: Each service starts with four 16-bit reads at base, base+2, base+4 and base+6. These return, in that order, the mode word, the count, the source pointer and the destination pointer. All are little-endian.
- R3: Mode bit 0 sets the unit size: 0 means bytes and 1 means 16-bit words. Byte accesses raise `memByte` and carry data on bits 7:0. A pointer that advances moves by 1 per byte unit and by 2 per word unit.
- R4: Mode bit 1 picks where data comes from. When it is 1, each unit is read from the source pointer. When it is 0, the source pointer value is itself the data (its low byte for byte units), no read is issued, and the source pointer never advances.
- R5: Mode bit 2 makes the source pointer advance after each unit, and mode bit 3 does the same for the destination pointer. When a bit is 0, that pointer stays fixed.
- R6: With mode bit 5 set (burst), one trigger performs all counted units in order. `hold` stays high from the first descriptor read until the one-cycle `done` pulse, and it is low while idle. Mode 0x0026 with count 5 over source bytes 0x11..0x55 leaves 0x55 at the fixed destination.
- R7: With mode bit 5 clear (single), a trigger with a nonzero count moves one unit. The engine then writes the decremented count, the source pointer and the destination pointer to base+2, base+4 and base+6, and pulses `done`.
- R8: A count of 0 moves no data, makes no access after the descriptor reads, and pulses `done`.
- R9: If the mode word has any bit of mask 0xFFD0 set (bit 4, bits 6 to 15), the engine pulses `err` instead of `done`, moves no data and returns to idle.
- R10: A valid trigger that arrives while the engine is busy is held in a one-entry pending slot and serviced after the current job. A further trigger that arrives while the slot is full is discarded.
- R11: While `memReq` is high and `memReady` is low, `memReq`, `memWe`, `memAddr` and `memWdata` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger strobe from the interrupt controller |
| trigLevel | input | 3 | Priority level of the triggering interrupt |
| trigBase | input | 16 | Descriptor base address from the interrupt vector |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memByte | output | 1 | 1 = byte access on bits 7:0, 0 = 16-bit access |
| memAddr | output | 16 | Byte address of the access |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid when memReady is high |
| memReady | input | 1 | Access completes at a clock edge where memReq and memReady are both high |
| hold | output | 1 | Engine busy; stalls the processor and other interrupts |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-mode pulse |

## Verification
The bench builds the engine with its default parameters: 16-bit words, a 3-bit level and a trigger level of 3'b111. These defaults match the descriptor layout, so every mode bit the engine supports and every rejected mode mask can be reached. A bench memory model answers after a random delay, which exercises the handshake hold (R11) in fetch, read, write and write-back phases. Random descriptors mix unit size, data source, both directions, burst versus single, and counts from 0 to 6. Directed cases cover the worked burst example, ignored trigger levels, rejected modes and a trigger queued behind a running job.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;
  localparam int MODE_UNIT16  = 0;
  localparam int MODE_FROMMEM = 1;
  localparam int MODE_SRCFWD  = 2;
  localparam int MODE_DSTFWD  = 3;
  localparam int MODE_BURST   = 5;
  localparam int DESC_WORDS   = 4;
  localparam logic [15:0] UNSUP_MASK = 16'hFFD0;

  typedef enum logic [1:0] {ADDR_DESC, ADDR_SRC, ADDR_DST, ADDR_WBACK} addrSel_e;

  typedef struct packed {
    logic     takePend;
    logic     loadField;
    logic     loadData;
    logic     stepUnit;
    addrSel_e addrSel;
    logic [1:0] idx;
  } pathCtl_t;
endpackage

// File: rtl/dmaeng_path.sv
module dmaeng_path
  import dmaeng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LVL_W = 3,
  parameter logic [LVL_W-1:0] TRIG_LEVEL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigValid,
  input  logic [LVL_W-1:0]  trigLevel,
  input  logic [WORD_W-1:0] trigBase,
  input  pathCtl_t          ctl,
  input  logic [WORD_W-1:0] memRdata,
  output logic              pendValid,
  output logic [WORD_W-1:0] modeWord,
  output logic              countIsZero,
  output logic              countIsOne,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);
  localparam int BYTE_W = 8;
  localparam logic [WORD_W-1:0] STEP_BYTE = WORD_W'(1);
  localparam logic [WORD_W-1:0] STEP_WORD = WORD_W'(2);

  logic [WORD_W-1:0] pendBase, baseReg, countReg, srcReg, dstReg, dataReg;
  logic [WORD_W-1:0] unitStep, payload, descOff, wbOff;
  logic accept;

  assign accept = trigValid && (trigLevel == TRIG_LEVEL) && (!pendValid || ctl.takePend);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendBase  <= '0;
    end else if (accept) begin
      pendValid <= 1'b1;
      pendBase  <= trigBase;
    end else if (ctl.takePend) begin
      pendValid <= 1'b0;
    end
  end

  assign unitStep = modeWord[MODE_UNIT16] ? STEP_WORD : STEP_BYTE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      modeWord <= '0;
      countReg <= '0;
      srcReg   <= '0;
      dstReg   <= '0;
      dataReg  <= '0;
    end else begin
      if (ctl.takePend) baseReg <= pendBase;
      if (ctl.loadField) begin
        case (ctl.idx)
          2'd0:    modeWord <= memRdata;
          2'd1:    countReg <= memRdata;
          2'd2:    srcReg   <= memRdata;
          default: dstReg   <= memRdata;
        endcase
      end
      if (ctl.loadData)
        dataReg <= modeWord[MODE_UNIT16] ? memRdata
                 : {{(WORD_W-BYTE_W){1'b0}}, memRdata[BYTE_W-1:0]};
      if (ctl.stepUnit) begin
        countReg <= countReg - WORD_W'(1);
        if (modeWord[MODE_FROMMEM] && modeWord[MODE_SRCFWD]) srcReg <= srcReg + unitStep;
        if (modeWord[MODE_DSTFWD]) dstReg <= dstReg + unitStep;
      end
    end
  end

  assign countIsZero = (countReg == '0);
  assign countIsOne  = (countReg == WORD_W'(1));

  assign descOff = WORD_W'(ctl.idx) << 1;
  assign wbOff   = (WORD_W'(ctl.idx) + WORD_W'(1)) << 1;

  always_comb begin
    case (ctl.addrSel)
      ADDR_DESC: memAddr = baseReg + descOff;
      ADDR_SRC:  memAddr = srcReg;
      ADDR_DST:  memAddr = dstReg;
      default:   memAddr = baseReg + wbOff;
    endcase
  end

  assign payload = modeWord[MODE_FROMMEM] ? dataReg : srcReg;

  always_comb begin
    if (ctl.addrSel == ADDR_WBACK) begin
      case (ctl.idx)
        2'd0:    memWdata = countReg;
        2'd1:    memWdata = srcReg;
        default: memWdata = dstReg;
      endcase
    end else if (modeWord[MODE_UNIT16]) begin
      memWdata = payload;
    end else begin
      memWdata = {{(WORD_W-BYTE_W){1'b0}}, payload[BYTE_W-1:0]};
    end
  end

  AST_LEVEL_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && trigLevel != TRIG_LEVEL && !pendValid && !ctl.takePend) |=> !pendValid); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepUnit |=> countReg == $past(countReg) - WORD_W'(1)); // R6
  AST_DST_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepUnit && !modeWord[MODE_DSTFWD]) |=> $stable(dstReg)); // R5
  AST_IMM_SRC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepUnit && !modeWord[MODE_FROMMEM]) |=> $stable(srcReg)); // R4
endmodule

// File: rtl/dmaeng_ctrl.sv
module dmaeng_ctrl
  import dmaeng_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendValid,
  input  logic [WORD_W-1:0] modeWord,
  input  logic              countIsZero,
  input  logic              countIsOne,
  input  logic              memReady,
  output pathCtl_t          ctl,
  output logic              memReq,
  output logic              memWe,
  output logic              memByte,
  output logic              hold,
  output logic              done,
  output logic              err
);
  localparam logic [1:0] LAST_DESC  = 2'(DESC_WORDS - 1);
  localparam logic [1:0] LAST_WBACK = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_WBACK, S_FINISH} state_e;
  state_e state;
  logic [1:0] idx;
  logic errSel, unsupported;

  assign unsupported = |(modeWord & WORD_W'(UNSUP_MASK));

  always_comb begin
    ctl = '0;
    ctl.idx = idx;
    ctl.takePend  = (state == S_IDLE) && pendValid;
    ctl.loadField = (state == S_FETCH) && memReady;
    ctl.loadData  = (state == S_READ) && memReady;
    ctl.stepUnit  = (state == S_WRITE) && memReady;
    case (state)
      S_READ:  ctl.addrSel = ADDR_SRC;
      S_WRITE: ctl.addrSel = ADDR_DST;
      S_WBACK: ctl.addrSel = ADDR_WBACK;
      default: ctl.addrSel = ADDR_DESC;
    endcase
  end

  assign memReq  = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE) || (state == S_WBACK);
  assign memWe   = (state == S_WRITE) || (state == S_WBACK);
  assign memByte = ((state == S_READ) || (state == S_WRITE)) && !modeWord[MODE_UNIT16];
  assign hold    = (state != S_IDLE);
  assign done    = (state == S_FINISH) && !errSel;
  assign err     = (state == S_FINISH) && errSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      idx    <= '0;
      errSel <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pendValid) begin
          state <= S_FETCH;
          idx   <= '0;
        end
        S_FETCH: if (memReady) begin
          if (idx == LAST_DESC) state <= S_CHECK;
          idx <= idx + 2'd1;
        end
        S_CHECK: begin
          errSel <= unsupported;
          if (unsupported || countIsZero) state <= S_FINISH;
          else if (modeWord[MODE_FROMMEM]) state <= S_READ;
          else state <= S_WRITE;
        end
        S_READ: if (memReady) state <= S_WRITE;
        S_WRITE: if (memReady) begin
          if (!modeWord[MODE_BURST]) begin
            state <= S_WBACK;
            idx   <= '0;
          end else if (countIsOne) begin
            state <= S_FINISH;
          end else if (modeWord[MODE_FROMMEM]) begin
            state <= S_READ;
          end
        end
        S_WBACK: if (memReady) begin
          if (idx == LAST_WBACK) state <= S_FINISH;
          idx <= idx + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe) && $stable(memByte))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !hold |-> !memReq); // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err)); // R9
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(state) == S_CHECK); // R9
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && countIsZero && !unsupported) |=> done); // R8
endmodule

// File: rtl/dmaeng_top.sv
module dmaeng_top
  import dmaeng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LVL_W = 3,
  parameter logic [LVL_W-1:0] TRIG_LEVEL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigValid,
  input  logic [LVL_W-1:0]  trigLevel,
  input  logic [WORD_W-1:0] trigBase,
  output logic              memReq,
  output logic              memWe,
  output logic              memByte,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic              hold,
  output logic              done,
  output logic              err
);
  pathCtl_t ctl;
  logic pendValid, countIsZero, countIsOne;
  logic [WORD_W-1:0] modeWord;

  dmaeng_path #(.WORD_W(WORD_W), .LVL_W(LVL_W), .TRIG_LEVEL(TRIG_LEVEL)) u_path (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigLevel(trigLevel),
    .trigBase(trigBase), .ctl(ctl), .memRdata(memRdata), .pendValid(pendValid),
    .modeWord(modeWord), .countIsZero(countIsZero), .countIsOne(countIsOne),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  dmaeng_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .modeWord(modeWord),
    .countIsZero(countIsZero), .countIsOne(countIsOne), .memReady(memReady),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .memByte(memByte),
    .hold(hold), .done(done), .err(err)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && $stable(memWdata))); // R11
endmodule

// File: tb/dmaeng_top_tb.sv
module dmaeng_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES = 1024;

  logic clk = 1'b0, rstN = 1'b0;
  logic trigValid = 1'b0;
  logic [2:0] trigLevel = 3'd0;
  logic [15:0] trigBase = 16'd0;
  logic memReq, memWe, memByte, hold, done, err;
  logic memReady = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] expMem [MEM_BYTES];
  logic [15:0] logAddr [256];
  logic logWe [256];
  int accCnt = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaeng_top u_dut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigLevel(trigLevel), .trigBase(trigBase),
    .memReq(memReq), .memWe(memWe), .memByte(memByte), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .hold(hold), .done(done), .err(err)
  );

  assign memRdata = memByte ? {8'h00, mem[memAddr[9:0]]}
                            : {mem[memAddr[9:0] + 10'd1], mem[memAddr[9:0]]};

  always @(negedge clk) memReady <= memReq && ($urandom_range(0, 2) != 0);

  always @(posedge clk) begin
    if (memReq && memReady) begin
      if (memWe) begin
        mem[memAddr[9:0]] <= memWdata[7:0];
        if (!memByte) mem[memAddr[9:0] + 10'd1] <= memWdata[15:8];
      end
      logAddr[accCnt[7:0]] <= memAddr;
      logWe[accCnt[7:0]] <= memWe;
      accCnt <= accCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] erd16(input logic [15:0] a);
    return {expMem[a[9:0] + 10'd1], expMem[a[9:0]]};
  endfunction

  task automatic ewr16(input logic [15:0] a, input logic [15:0] d);
    expMem[a[9:0]] = d[7:0];
    expMem[a[9:0] + 10'd1] = d[15:8];
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    mem[a[9:0]] = d;
    expMem[a[9:0]] = d;
  endtask

  task automatic putDesc(input logic [15:0] b, input logic [15:0] m, input logic [15:0] c,
                         input logic [15:0] s, input logic [15:0] d);
    poke(b, m[7:0]);      poke(b + 16'd1, m[15:8]);
    poke(b + 16'd2, c[7:0]); poke(b + 16'd3, c[15:8]);
    poke(b + 16'd4, s[7:0]); poke(b + 16'd5, s[15:8]);
    poke(b + 16'd6, d[7:0]); poke(b + 16'd7, d[15:8]);
  endtask

  // Reference behaviour computed from the requirements on the shadow memory
  task automatic model(input logic [15:0] b, output bit isErr);
    logic [15:0] m, c, s, d, dat, st;
    m = erd16(b); c = erd16(b + 16'd2); s = erd16(b + 16'd4); d = erd16(b + 16'd6);
    isErr = (m & 16'hFFD0) != 16'd0;
    if (isErr || c == 16'd0) return;
    st = m[0] ? 16'd2 : 16'd1;
    for (int n = 0; n < (m[5] ? int'(c) : 1); n++) begin
      if (m[1]) dat = m[0] ? erd16(s) : {8'h00, expMem[s[9:0]]};
      else dat = s;
      if (m[0]) ewr16(d, dat); else expMem[d[9:0]] = dat[7:0];
      if (m[1] && m[2]) s = s + st;
      if (m[3]) d = d + st;
    end
    if (!m[5]) begin
      ewr16(b + 16'd2, c - 16'd1);
      ewr16(b + 16'd4, s);
      ewr16(b + 16'd6, d);
    end
  endtask

  task automatic cmpMem(input string tag);
    int bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== expMem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic fire(input logic [15:0] b, input logic [2:0] lvl);
    @(negedge clk);
    trigValid = 1'b1; trigBase = b; trigLevel = lvl;
    @(negedge clk);
    trigValid = 1'b0;
  endtask

  task automatic waitEnd(input string tag, output bit sawErr);
    bit started = 0, dropped = 0, ended = 0;
    sawErr = 0;
    for (int t = 0; t < 3000 && !ended; t++) begin
      if (hold) started = 1;
      if (started && !hold) dropped = 1;
      if (done || err) begin sawErr = err; ended = 1; end
      else @(negedge clk);
    end
    chk({tag, " finished"}, ended, 1);
    chk({tag, " hold continuous (R6)"}, dropped, 0);
    @(negedge clk);
  endtask

  task automatic runJob(input string tag, input logic [15:0] b, input bit wantErr);
    bit e, se;
    fire(b, 3'b111);
    waitEnd(tag, se);
    model(b, e);
    chk({tag, " outcome"}, se, wantErr);
    cmpMem({tag, " memory"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int a0;
    bit se;
    void'($urandom(32'd4711));
    for (int i = 0; i < MEM_BYTES; i++) begin mem[i] = 8'h00; expMem[i] = 8'h00; end
    for (int i = 16'h100; i < 16'h200; i++) poke(16'(i), 8'($urandom));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset hold", hold, 0);
    chk("R11 reset memReq", memReq, 0);
    chk("R6 reset done", {done, err}, 0);

    // R1: wrong level ignored
    putDesc(16'h0000, 16'h0026, 16'd3, 16'h0100, 16'h0280);
    begin
      bit rose = 0;
      fire(16'h0000, 3'b011);
      for (int t = 0; t < 20; t++) begin if (hold || memReq) rose = 1; @(negedge clk); end
      chk("R1 low level ignored", rose, 0);
      cmpMem("R1 memory untouched");
    end

    // R6/R2: worked burst example
    for (int k = 0; k < 5; k++) poke(16'h0120 + 16'(k), 8'(8'h11 * (k + 1)));
    putDesc(16'h0008, 16'h0026, 16'd5, 16'h0120, 16'h0250);
    a0 = accCnt;
    runJob("R6 burst example", 16'h0008, 0);
    chk("R6 fixed destination holds last byte", mem[16'h250], 8'h55);
    for (int k = 0; k < 4; k++) begin
      chk("R2 descriptor read address", logAddr[8'(a0 + k)], 16'h0008 + 16'(2 * k));
      chk("R2 descriptor read direction", logWe[8'(a0 + k)], 0);
    end
    @(negedge clk);
    chk("R6 done one cycle", done, 0);

    // R8: zero count
    putDesc(16'h0010, 16'h0026, 16'd0, 16'h0120, 16'h0260);
    a0 = accCnt;
    runJob("R8 zero count", 16'h0010, 0);
    chk("R8 only descriptor accesses", accCnt - a0, 4);

    // R9: unsupported modes
    putDesc(16'h0018, 16'h0036, 16'd2, 16'h0120, 16'h0260);
    a0 = accCnt;
    runJob("R9 calculation mode", 16'h0018, 1);
    chk("R9 no transfer accesses", accCnt - a0, 4);
    putDesc(16'h0020, 16'h0426, 16'd2, 16'h0120, 16'h0260);
    runJob("R9 reserved bit", 16'h0020, 1);
    putDesc(16'h0028, 16'h8066, 16'd2, 16'h0120, 16'h0260);
    runJob("R9 multiple and interrupt bits", 16'h0028, 1);

    // R7: single mode with write-back
    putDesc(16'h0030, 16'h0006, 16'd3, 16'h0130, 16'h0270);
    runJob("R7 single step one", 16'h0030, 0);
    chk("R7 count written back", {mem[16'h33], mem[16'h32]}, 16'd2);
    chk("R7 source advanced", {mem[16'h35], mem[16'h34]}, 16'h0131);
    runJob("R7 single step two", 16'h0030, 0);

    // R3/R4: immediate 16-bit burst with forward destination
    putDesc(16'h0038, 16'h0029, 16'd3, 16'hBEEF, 16'h0290);
    runJob("R4 immediate words", 16'h0038, 0);
    chk("R3 word step lands at +4", {mem[16'h295], mem[16'h294]}, 16'hBEEF);
    chk("R4 source field unchanged", {mem[16'h3D], mem[16'h3C]}, 16'hBEEF);

    // R10: trigger while busy is queued
    putDesc(16'h0040, 16'h002D, 16'd6, 16'h0140, 16'h02A0);
    putDesc(16'h0048, 16'h0027, 16'd4, 16'h0150, 16'h02C0);
    fire(16'h0040, 3'b111);
    fire(16'h0048, 3'b111);
    chk("R10 busy when second trigger sent", hold, 1);
    waitEnd("R10 first job", se);
    begin
      bit e1, e2;
      waitEnd("R10 queued job", se);
      model(16'h0040, e1);
      model(16'h0048, e2);
      cmpMem("R10 both jobs applied");
    end

    // Random descriptors over R3, R4, R5, R6, R7, R8
    for (int i = 0; i < 24; i++) begin
      logic [15:0] b, m;
      b = 16'h0080 + 16'(8 * i);
      m = 16'($urandom) & 16'h002F;
      putDesc(b, m, 16'($urandom_range(0, 6)), 16'h0100 + 16'($urandom_range(0, 127)),
              16'h0200 + 16'($urandom_range(0, 127)));
      runJob("R5 random descriptor", b, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule